// File: doc/BRIEF.md
# Clock Root Configuration and Update Controller

This block is the register side of a programmable clock root. Software writes a shadow set of settings: source code, pre-divider, counter mode, a hardware-control bit and the three M/N/D counter values. None of these writes changes the outputs that drive the downstream divider and selector. When software writes the apply bit in the command register, the block copies the whole shadow set into the active set in one step. It then clears the apply bit, so software can poll it for completion. The copy finishes one cycle after the request, well inside any polling budget.

The command register also holds a force-on bit and per-register dirty flags. A root-off status bit reads 1 while neither the force-on bit nor the downstream enable input keeps the root running. The register port is a valid/ready request channel. `reg_ready` is tied high, so there is never back-pressure and a request is taken in every cycle where `reg_valid` is high. A write takes effect at that clock edge. A read returns its data on `reg_rdata` in the same cycle, combinationally. The active set comes out as registered codes; the glitch-free clock switching is done elsewhere.

Top module: `clk_root_ctrl`

## Requirements
- R1: After a synchronous active-low reset the active set is all zero (source 0, divider 0, mode 0, hardware-control 0, M/N/D 0), `root_off` is 1, and the command register (address 0) reads 0x8000_0000.
- R2: A write to a shadow register is returned on read-back at once. It leaves every active output unchanged until an apply completes. Addresses: configuration 1, M 2, N 3, D 4; M/N/D occupy bits 7:0.
- R3: Writing 1 to command bit 0 (apply) sets that bit. It reads 1 in the next cycle, and in that cycle the outputs still hold the old set. One cycle later the active outputs equal the shadow set and bit 0 reads 0.
- R4: Command bits 4, 5, 6, 7 are dirty flags for the configuration, N, M and D shadow registers. A write sets the flag, and a completed apply clears it. A write in the cycle the apply completes leaves its flag set.
- R5: A shadow write made while an apply is pending is accepted into the shadow register. It reaches the active outputs only through a later apply.
- R6: Command bit 1 is a read/write force-on bit. `root_off`, which command bit 31 mirrors, equals the inverse of (force-on OR `dn_enable`) as sampled one clock earlier.
- R7: The configuration register holds the pre-divider at bits 4:0, the source code at 10:8, the mode at 13:12 and hardware control at bit 20. All other bits are ignored on write and read 0.
- R8: Accesses to addresses 5 to 7 read 0, and writes to them change no register and no flag.
- R9: `reg_ready` is always 1. `reg_rdata` is 0 unless `reg_valid` is high with `reg_write` low.
- R10: A command write with bit 0 clear starts no apply. `dual_edge` is 1 exactly when the active mode is 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_valid | input | 1 | Register request valid |
| reg_ready | output | 1 | Request accepted (always 1) |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, same cycle |
| dn_enable | input | 1 | Downstream request to keep the root running |
| root_off | output | 1 | Root is off |
| src_code | output | 3 | Active source-select code |
| pre_div | output | 5 | Active pre-divider |
| cnt_mode | output | 2 | Active counter mode |
| hw_ctl | output | 1 | Active hardware-control bit |
| m_val | output | 8 | Active M value |
| n_val | output | 8 | Active N value |
| d_val | output | 8 | Active D value |
| dual_edge | output | 1 | Active mode is dual-edge (2) |

## Verification
The bench checks that the outputs do not move while only shadow writes have been made. A design that forwarded shadow writes would change `pre_div` before any apply. It samples the single pending cycle, where a design that copied at once, or never cleared the apply bit, shows the wrong bit 0 or early outputs. It writes the configuration in the very cycle the copy happens: the active set must keep the old value while the dirty flag stays set, which catches a clear that beats the set. It also measures the one-cycle lag of `root_off` from both sources, masks junk bits in the configuration word, and probes the unmapped addresses.

// File: rtl/clk_root_pkg.sv
package clk_root_pkg;
  localparam int CR_DATA_W = 32;
  localparam int CR_ADDR_W = 3;
  localparam int CR_DIV_W  = 5;
  localparam int CR_SRC_W  = 3;
  localparam int CR_MODE_W = 2;
  localparam int CR_MND_W  = 8;
  localparam int CR_NMND   = 3;   // N, M, D in dirty-flag order

  localparam int CFG_SRC_LSB  = 8;
  localparam int CFG_MODE_LSB = 12;
  localparam int CFG_HW_BIT   = 20;
  localparam int CMD_APPLY    = 0;
  localparam int CMD_FORCE    = 1;
  localparam int CMD_DIRTY_LSB = 4;
  localparam int CMD_OFF_BIT  = 31;

  localparam logic [CR_ADDR_W-1:0] ADR_CMD = 3'd0;
  localparam logic [CR_ADDR_W-1:0] ADR_CFG = 3'd1;
  localparam logic [CR_ADDR_W-1:0] ADR_M   = 3'd2;
  localparam logic [CR_ADDR_W-1:0] ADR_N   = 3'd3;
  localparam logic [CR_ADDR_W-1:0] ADR_D   = 3'd4;

  localparam logic [CR_MODE_W-1:0] MODE_DUAL = 2'd2;

  typedef struct packed {
    logic [CR_DIV_W-1:0]  div;
    logic [CR_SRC_W-1:0]  src;
    logic [CR_MODE_W-1:0] mode;
    logic                 hw;
    logic [CR_MND_W-1:0]  m;
    logic [CR_MND_W-1:0]  n;
    logic [CR_MND_W-1:0]  d;
  } cr_set_t;
endpackage

// File: rtl/clk_root_cmd.sv
module clk_root_cmd
  import clk_root_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_we,
  input  logic                 apply_bit,
  input  logic                 force_bit,
  input  logic [CR_NMND:0]     shadow_we,   // cfg, N, M, D
  input  logic                 dn_en,
  output logic                 commit,
  output logic                 force_on,
  output logic [CR_NMND:0]     dirty,
  output logic                 root_off
);
  logic pending_q, root_on_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending_q <= 1'b0;
      force_on  <= 1'b0;
      dirty     <= '0;
      root_on_q <= 1'b0;
    end else begin
      if (pending_q)                  pending_q <= 1'b0;
      else if (cmd_we && apply_bit)   pending_q <= 1'b1;
      if (cmd_we) force_on <= force_bit;
      dirty     <= (pending_q ? '0 : dirty) | shadow_we;
      root_on_q <= force_on | dn_en;
    end
  end

  assign commit   = pending_q;
  assign root_off = ~root_on_q;

  a_r3_single_pending: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !commit);
  a_r4_dirty_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && shadow_we == '0) |=> dirty == '0);
  a_r6_root_off_lag: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (root_off == !$past(force_on | dn_en)));
endmodule

// File: rtl/clk_root_shadow.sv
module clk_root_shadow
  import clk_root_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_cfg,
  input  logic [CR_NMND-1:0]   wr_mnd,      // N, M, D
  input  logic [CR_DIV_W-1:0]  div_in,
  input  logic [CR_SRC_W-1:0]  src_in,
  input  logic [CR_MODE_W-1:0] mode_in,
  input  logic                 hw_in,
  input  logic [CR_MND_W-1:0]  mnd_in,
  output cr_set_t              shd
);
  logic [CR_DIV_W-1:0]  div_q;
  logic [CR_SRC_W-1:0]  src_q;
  logic [CR_MODE_W-1:0] mode_q;
  logic                 hw_q;
  logic [CR_MND_W-1:0]  mnd_q [CR_NMND];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q <= '0; src_q <= '0; mode_q <= '0; hw_q <= 1'b0;
    end else if (wr_cfg) begin
      div_q <= div_in; src_q <= src_in; mode_q <= mode_in; hw_q <= hw_in;
    end
  end

  for (genvar i = 0; i < CR_NMND; i++) begin : g_mnd
    always_ff @(posedge clk) begin
      if (!rst_n)         mnd_q[i] <= '0;
      else if (wr_mnd[i]) mnd_q[i] <= mnd_in;
    end
  end

  always_comb begin
    shd      = '0;
    shd.div  = div_q;
    shd.src  = src_q;
    shd.mode = mode_q;
    shd.hw   = hw_q;
    shd.n    = mnd_q[0];
    shd.m    = mnd_q[1];
    shd.d    = mnd_q[2];
  end
endmodule

// File: rtl/clk_root_active.sv
module clk_root_active
  import clk_root_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    commit,
  input  cr_set_t shd,
  output cr_set_t act
);
  always_ff @(posedge clk) begin
    if (!rst_n)      act <= '0;
    else if (commit) act <= shd;
  end

  a_r2_hold_without_apply: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(act));
  a_r3_load_on_apply: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> act == $past(shd));
endmodule

// File: rtl/clk_root_ctrl.sv
module clk_root_ctrl
  import clk_root_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_valid,
  output logic                 reg_ready,
  input  logic                 reg_write,
  input  logic [CR_ADDR_W-1:0] reg_addr,
  input  logic [CR_DATA_W-1:0] reg_wdata,
  output logic [CR_DATA_W-1:0] reg_rdata,
  input  logic                 dn_enable,
  output logic                 root_off,
  output logic [CR_SRC_W-1:0]  src_code,
  output logic [CR_DIV_W-1:0]  pre_div,
  output logic [CR_MODE_W-1:0] cnt_mode,
  output logic                 hw_ctl,
  output logic [CR_MND_W-1:0]  m_val,
  output logic [CR_MND_W-1:0]  n_val,
  output logic [CR_MND_W-1:0]  d_val,
  output logic                 dual_edge
);
  logic               wr, rd, cmd_we, wr_cfg, commit, force_on;
  logic [CR_NMND-1:0] wr_mnd;
  logic [CR_NMND:0]   dirty;
  cr_set_t            shd, act;

  assign reg_ready = 1'b1;
  assign wr     = reg_valid && reg_write;
  assign rd     = reg_valid && !reg_write;
  assign cmd_we = wr && (reg_addr == ADR_CMD);
  assign wr_cfg = wr && (reg_addr == ADR_CFG);
  assign wr_mnd = {wr && (reg_addr == ADR_D), wr && (reg_addr == ADR_M),
                   wr && (reg_addr == ADR_N)};

  logic unused_wbits;
  assign unused_wbits = ^{reg_wdata[CR_DATA_W-1:CFG_HW_BIT+1],
                          reg_wdata[CFG_HW_BIT-1:CFG_MODE_LSB+CR_MODE_W],
                          reg_wdata[CFG_MODE_LSB-1:CFG_SRC_LSB+CR_SRC_W]};

  clk_root_cmd u_cmd (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we),
    .apply_bit(reg_wdata[CMD_APPLY]), .force_bit(reg_wdata[CMD_FORCE]),
    .shadow_we({wr_mnd, wr_cfg}), .dn_en(dn_enable),
    .commit(commit), .force_on(force_on), .dirty(dirty), .root_off(root_off)
  );

  clk_root_shadow u_shadow (
    .clk(clk), .rst_n(rst_n), .wr_cfg(wr_cfg), .wr_mnd(wr_mnd),
    .div_in(reg_wdata[CR_DIV_W-1:0]),
    .src_in(reg_wdata[CFG_SRC_LSB +: CR_SRC_W]),
    .mode_in(reg_wdata[CFG_MODE_LSB +: CR_MODE_W]),
    .hw_in(reg_wdata[CFG_HW_BIT]),
    .mnd_in(reg_wdata[CR_MND_W-1:0]),
    .shd(shd)
  );

  clk_root_active u_active (
    .clk(clk), .rst_n(rst_n), .commit(commit), .shd(shd), .act(act)
  );

  always_comb begin
    reg_rdata = '0;
    if (rd) begin
      case (reg_addr)
        ADR_CMD: begin
          reg_rdata[CMD_APPLY]   = commit;
          reg_rdata[CMD_FORCE]   = force_on;
          reg_rdata[CMD_DIRTY_LSB +: CR_NMND+1] = dirty;
          reg_rdata[CMD_OFF_BIT] = root_off;
        end
        ADR_CFG: begin
          reg_rdata[CR_DIV_W-1:0]              = shd.div;
          reg_rdata[CFG_SRC_LSB +: CR_SRC_W]   = shd.src;
          reg_rdata[CFG_MODE_LSB +: CR_MODE_W] = shd.mode;
          reg_rdata[CFG_HW_BIT]                = shd.hw;
        end
        ADR_M:   reg_rdata[CR_MND_W-1:0] = shd.m;
        ADR_N:   reg_rdata[CR_MND_W-1:0] = shd.n;
        ADR_D:   reg_rdata[CR_MND_W-1:0] = shd.d;
        default: reg_rdata = '0;
      endcase
    end
  end

  assign src_code  = act.src;
  assign pre_div   = act.div;
  assign cnt_mode  = act.mode;
  assign hw_ctl    = act.hw;
  assign m_val     = act.m;
  assign n_val     = act.n;
  assign d_val     = act.d;
  assign dual_edge = (act.mode == MODE_DUAL);

  a_r9_ready_high: assert property (@(posedge clk) disable iff (!rst_n)
    reg_ready);
endmodule

// File: tb/clk_root_ctrl_bench.sv
module clk_root_ctrl_bench;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        reg_valid = 1'b0, reg_write = 1'b0, dn_enable = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        reg_ready, root_off, hw_ctl, dual_edge;
  logic [31:0] reg_rdata;
  logic [2:0]  src_code;
  logic [4:0]  pre_div;
  logic [1:0]  cnt_mode;
  logic [7:0]  m_val, n_val, d_val;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  clk_root_ctrl u_clk_root_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_ready(reg_ready),
    .reg_write(reg_write), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .dn_enable(dn_enable), .root_off(root_off),
    .src_code(src_code), .pre_div(pre_div), .cnt_mode(cnt_mode),
    .hw_ctl(hw_ctl), .m_val(m_val), .n_val(n_val), .d_val(d_val),
    .dual_edge(dual_edge)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // called just after a falling edge; returns after the write edge, at the next falling edge
  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_valid = 1'b1; reg_write = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_valid = 1'b0; reg_write = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_valid = 1'b1; reg_write = 1'b0; reg_addr = a;
    #1 d = reg_rdata;
    reg_valid = 1'b0;
  endtask

  task automatic chk_out(input string tag, input logic [31:0] exp_cfg,
                         input logic [7:0] em, input logic [7:0] en, input logic [7:0] ed);
    chk({tag, " pre_div"},  {27'b0, pre_div},  {27'b0, exp_cfg[4:0]});
    chk({tag, " src_code"}, {29'b0, src_code}, {29'b0, exp_cfg[10:8]});
    chk({tag, " cnt_mode"}, {30'b0, cnt_mode}, {30'b0, exp_cfg[13:12]});
    chk({tag, " hw_ctl"},   {31'b0, hw_ctl},   {31'b0, exp_cfg[20]});
    chk({tag, " m/n/d"},    {8'b0, m_val, n_val, d_val}, {8'b0, em, en, ed});
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 root_off", {31'b0, root_off}, 32'd1);
    chk_out("R1", 32'h0, 8'h0, 8'h0, 8'h0);
    rd(3'd0, v); chk("R1 cmd read", v, 32'h8000_0000);
  endtask

  task automatic t_shadow();
    logic [31:0] v;
    wr(3'd1, 32'h0010_2513 | 32'hFFE0_0000 | 32'h000F_C000 | 32'h0000_0800);
    wr(3'd2, 32'hFFFF_FF11);
    wr(3'd3, 32'h0000_00E0);
    wr(3'd4, 32'h0000_003C);
    rd(3'd1, v); chk("R7 cfg readback masked", v, 32'h0010_2513);
    rd(3'd2, v); chk("R2 M readback", v, 32'h11);
    rd(3'd3, v); chk("R2 N readback", v, 32'hE0);
    chk_out("R2 no effect before apply", 32'h0, 8'h0, 8'h0, 8'h0);
    rd(3'd0, v); chk("R4 dirty all set", v, 32'h8000_00F0);
  endtask

  task automatic t_update();
    logic [31:0] v;
    wr(3'd0, 32'h1);
    rd(3'd0, v); chk("R3 apply pending", v[0], 1'b1);
    chk("R3 outputs old while pending", {27'b0, pre_div}, 32'd0);
    @(negedge clk);
    chk_out("R3 applied", 32'h0010_2513, 8'h11, 8'hE0, 8'h3C);
    chk("R10 dual_edge for mode 2", {31'b0, dual_edge}, 32'd1);
    rd(3'd0, v); chk("R4 dirty cleared, apply done", v, 32'h8000_0000);
  endtask

  task automatic t_pending_write();
    logic [31:0] v;
    wr(3'd0, 32'h1);
    wr(3'd1, 32'h0000_0001);        // lands in the cycle the copy happens
    chk_out("R5 old set kept", 32'h0010_2513, 8'h11, 8'hE0, 8'h3C);
    rd(3'd1, v); chk("R5 shadow took write", v, 32'h1);
    rd(3'd0, v); chk("R4 dirty cfg kept", v, 32'h8000_0010);
    wr(3'd0, 32'h1);
    @(negedge clk);
    chk_out("R5 later apply", 32'h1, 8'h11, 8'hE0, 8'h3C);
    chk("R10 dual_edge off for mode 0", {31'b0, dual_edge}, 32'd0);
  endtask

  task automatic t_no_apply();
    logic [31:0] v;
    wr(3'd2, 32'h55);
    wr(3'd0, 32'h0);
    @(negedge clk);
    chk("R10 no apply without bit 0", {24'b0, m_val}, 32'h11);
    rd(3'd0, v); chk("R10 cmd bit0 clear", v, 32'h8000_0040);
  endtask

  task automatic t_root();
    logic [31:0] v;
    wr(3'd0, 32'h2);
    chk("R6 root_off lags force", {31'b0, root_off}, 32'd1);
    rd(3'd0, v); chk("R6 force bit reads 1", v[1], 1'b1);
    @(negedge clk);
    chk("R6 root on by force", {31'b0, root_off}, 32'd0);
    rd(3'd0, v); chk("R6 cmd bit31 clear", v[31], 1'b0);
    wr(3'd0, 32'h0);
    chk("R6 still on one cycle", {31'b0, root_off}, 32'd0);
    @(negedge clk);
    chk("R6 off again", {31'b0, root_off}, 32'd1);
    dn_enable = 1'b1;
    #1 chk("R6 dn_enable lags", {31'b0, root_off}, 32'd1);
    @(negedge clk);
    chk("R6 on by dn_enable", {31'b0, root_off}, 32'd0);
    dn_enable = 1'b0;
    @(negedge clk);
    chk("R6 off after dn_enable drop", {31'b0, root_off}, 32'd1);
  endtask

  task automatic t_unmapped();
    logic [31:0] v;
    wr(3'd5, 32'hFFFF_FFFF);
    wr(3'd7, 32'hFFFF_FFFF);
    rd(3'd5, v); chk("R8 unmapped reads 0", v, 32'h0);
    rd(3'd1, v); chk("R8 cfg untouched", v, 32'h1);
    rd(3'd0, v); chk("R8 flags untouched", v, 32'h8000_0040);
    chk("R9 ready high", {31'b0, reg_ready}, 32'd1);
    #1 chk("R9 rdata 0 without valid", reg_rdata, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_shadow();
    t_update();
    t_pending_write();
    t_no_apply();
    t_root();
    t_unmapped();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule